// File: doc/BRIEF.md
# SMBus Register Slave Interface

This block is a bus-side slave for a two-wire SMBus/I2C-style serial bus that gives a host access to a small register file held elsewhere in the chip. It oversamples the clock line (SCL) and the data line (SDA) with the system clock and recognises start, repeated start and stop conditions. It compares the 7-bit address in the first byte against its own, and it pulls SDA low for acknowledge bits and for read data. It never drives SDA high: the bus is open-drain, and `sda_pull` high means "pull the line low".

Four transactions are supported: byte write, byte read, block write and block read. Every transaction opens with the address and a write bit, followed by a command code. Bit 7 of the command code chooses single-byte or block operation, and bits 6:0 give the first register. Block writes carry a byte count from the master after the command code. Block reads return a byte count first, after a repeated start with the read bit set. The register pointer advances after each data byte. On the core side the block gives a one-cycle write strobe with address and data, and it takes read data combinationally from the address it presents.

Top module: `smb_regslave`

## Requirements
- R1: A start followed by an address byte whose upper 7 bits equal `SLAVE_ADDR` is acknowledged (SDA held low during the ninth clock). For any other address SDA is left released for that bit and for every later bit, and no register is written, until the next start or stop.
- R2: The byte after a matching write address is the command code and is acknowledged. Bit 7 = 1 selects block mode and bit 7 = 0 selects single-byte mode. Bits 6:0 load the register pointer.
- R3: In single-byte mode, the first data byte after the command code is acknowledged and written to the register at the pointer. Any further data byte in the same transfer is not acknowledged and not written.
- R4: In block mode, the byte after the command code is a count N, which is acknowledged. The next N data bytes are acknowledged and written to consecutive registers starting at the pointer, with the pointer wrapping from 127 to 0. Data bytes beyond N are not acknowledged and not written.
- R5: After a command code in single-byte mode, a repeated start with the matching address and read bit 1 is acknowledged. The block then sends the register at the pointer, most significant bit first.
- R6: After a command code in block mode, a repeated start with the matching address and read bit 1 is acknowledged. The block then sends `BLOCK_COUNT` (default 8) and then registers pointer, pointer+1, and so on, one per byte the master acknowledges. After the master's not-acknowledge, SDA stays released until the next start or stop.
- R7: A stop in the middle of a byte ends the transfer, and a start in the middle of a byte restarts address reception. In neither case is the partial byte written.
- R8: The block changes its SDA drive only while SCL is low. It samples SDA on rising SCL. An acknowledge is driven from the SCL fall after the eighth bit until the following fall.
- R9: Each accepted write byte produces exactly one single-cycle write strobe, and no strobe occurs otherwise.
- R10: After reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_addr | output | 7 | Register address (write target or read source) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Read data for the register at `reg_addr` |

## Verification
When the last byte allowed by a block-write count completes, three things happen in the same clock: the write strobe is issued, the remaining count reaches zero, and the block begins to refuse further bytes. A wrong count at this point would either drop the last byte or accept one too many. The bench provokes this with block writes that send one extra byte after the announced count, one of them wrapping the pointer from 127 to 0. The scoreboard must then hold exactly the announced writes at the expected addresses, and the extra byte must see SDA high in its acknowledge slot.

// File: rtl/smb_pkg.sv
// Shared types for the SMBus register slave.
// Assumes byte-wide bus transfers and a 7-bit register pointer.
package smb_pkg;

    localparam int SMB_BYTE_W = 8;
    localparam int SMB_PTR_W  = SMB_BYTE_W - 1;

    // Protocol sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } smb_state_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_COUNT,
        K_DATA
    } rx_kind_t;

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the system clock domain and flags bus events.
// Assumes: system clock at least 8x SCL; bus idles high, so the
// synchronizer resets to 1 and no false condition appears after reset.
// Outputs rise/fall/start/stop are combinational single-cycle pulses.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Edge and condition decode: SDA moving while SCL stays high
    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

endmodule

// File: rtl/smb_rx_shift.sv
// Receive shifter: collects BITS serial bits MSB first on rising SCL and
// pulses byte_done one cycle after the last bit. A clear returns the bit
// counter to zero, discarding any partial byte.
module smb_rx_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            scl_rise,
    input  logic            sda_s,
    output logic [BITS-1:0] rx_byte,
    output logic            byte_done
);

    localparam int CW = $clog2(BITS);

    logic [CW-1:0] bit_cnt;

    // Shift in one bit per SCL rise and count to a full byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            bit_cnt   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
            end else if (shift_en && scl_rise) begin
                rx_byte <= {rx_byte[BITS-2:0], sda_s};
                if (bit_cnt == CW'(BITS - 1)) begin
                    bit_cnt   <= '0;
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(scl_rise)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R9

endmodule

// File: rtl/smb_proto_fsm.sv
// Protocol sequencer. It decodes received bytes as address, command code,
// count or data, and drives acknowledge and read bits on SDA. It also owns
// the register pointer and the block count.
// Assumes: rx bytes from smb_rx_shift, edge pulses from smb_line_sync,
// and reg_rdata valid combinationally for the address on reg_addr.
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter logic [SMB_PTR_W-1:0] SLAVE_ADDR  = 7'h3A,
    parameter int                   BLOCK_COUNT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_s,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [SMB_BYTE_W-1:0] rx_byte,
    input  logic                  byte_done,
    output logic                  rx_en,
    output logic                  rx_clear,
    output logic                  sda_pull,
    output logic                  reg_wr_en,
    output logic [SMB_PTR_W-1:0]  reg_addr,
    output logic [SMB_BYTE_W-1:0] reg_wdata,
    input  logic [SMB_BYTE_W-1:0] reg_rdata
);

    localparam int                    DW         = SMB_BYTE_W;
    localparam int                    TCW        = $clog2(DW + 1);
    localparam logic [DW-1:0]         COUNT_BYTE = DW'(BLOCK_COUNT);

    smb_state_t           state;
    rx_kind_t             kind;
    rx_kind_t             next_kind;
    logic                 go_tx;
    logic                 blk_mode;
    logic [SMB_PTR_W-1:0] ptr;
    logic [DW-1:0]        left;
    logic [DW-1:0]        tx_sh;
    logic [TCW-1:0]       tx_cnt;
    logic                 mack;
    logic                 mack_seen;
    logic [DW-1:0]        first_byte;

    // First byte of a read: the count in block mode, else register data
    assign first_byte = blk_mode ? COUNT_BYTE : reg_rdata;

    // The receive shifter runs only while a byte is expected
    assign rx_en    = (state == ST_RX);
    assign rx_clear = ~rx_en | start_det | stop_det;
    assign reg_addr = ptr;

    // Main sequencer: bus conditions first, then per-state SCL handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= K_ADDR;
            next_kind <= K_ADDR;
            go_tx     <= 1'b0;
            blk_mode  <= 1'b0;
            ptr       <= '0;
            left      <= '0;
            tx_sh     <= '0;
            tx_cnt    <= '0;
            mack      <= 1'b0;
            mack_seen <= 1'b0;
            sda_pull  <= 1'b0;
            reg_wr_en <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (reg_wr_en) begin
                ptr <= ptr + 1'b1;
            end
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_det) begin
                state    <= ST_RX;
                kind     <= K_ADDR;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (byte_done) begin
                            case (kind)
                                K_ADDR: begin
                                    if (rx_byte[DW-1:1] == SLAVE_ADDR) begin
                                        go_tx     <= rx_byte[0];
                                        next_kind <= K_CMD;
                                        state     <= ST_ACK_WAIT;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                K_CMD: begin
                                    blk_mode  <= rx_byte[DW-1];
                                    ptr       <= rx_byte[SMB_PTR_W-1:0];
                                    left      <= rx_byte[DW-1] ? '0 : DW'(1);
                                    next_kind <= rx_byte[DW-1] ? K_COUNT : K_DATA;
                                    go_tx     <= 1'b0;
                                    state     <= ST_ACK_WAIT;
                                end
                                K_COUNT: begin
                                    left      <= rx_byte;
                                    next_kind <= K_DATA;
                                    state     <= ST_ACK_WAIT;
                                end
                                default: begin
                                    if (left != '0) begin
                                        reg_wr_en <= 1'b1;
                                        reg_wdata <= rx_byte;
                                        left      <= left - 1'b1;
                                        next_kind <= K_DATA;
                                        state     <= ST_ACK_WAIT;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK_HOLD;
                        end
                    end
                    ST_ACK_HOLD: begin
                        if (scl_fall) begin
                            if (go_tx) begin
                                sda_pull <= ~first_byte[DW-1];
                                tx_sh    <= {first_byte[DW-2:0], 1'b0};
                                tx_cnt   <= TCW'(1);
                                state    <= ST_TX;
                                if (!blk_mode) begin
                                    ptr <= ptr + 1'b1;
                                end
                            end else begin
                                sda_pull <= 1'b0;
                                kind     <= next_kind;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (tx_cnt == TCW'(DW)) begin
                                sda_pull  <= 1'b0;
                                mack_seen <= 1'b0;
                                state     <= ST_TX_ACK;
                            end else begin
                                sda_pull <= ~tx_sh[DW-1];
                                tx_sh    <= {tx_sh[DW-2:0], 1'b0};
                                tx_cnt   <= tx_cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack      <= ~sda_s;
                            mack_seen <= 1'b1;
                        end else if (scl_fall && mack_seen) begin
                            if (mack) begin
                                sda_pull <= ~reg_rdata[DW-1];
                                tx_sh    <= {reg_rdata[DW-2:0], 1'b0};
                                tx_cnt   <= TCW'(1);
                                ptr      <= ptr + 1'b1;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s); // R8

    AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(byte_done)); // R9

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R9

    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_pull); // R1

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)); // R7

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && kind == K_ADDR)); // R7

endmodule

// File: rtl/smb_regslave.sv
// SMBus register slave top. Ties the line synchronizer, the receive
// shifter and the protocol sequencer together. SDA is open-drain:
// sda_pull = 1 pulls the line low. Assumes clk >= 8x SCL and SYNC_STAGES >= 2.
module smb_regslave
    import smb_pkg::*;
#(
    parameter logic [SMB_PTR_W-1:0] SLAVE_ADDR  = 7'h3A,
    parameter int                   BLOCK_COUNT = 8,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull,
    output logic                  reg_wr_en,
    output logic [SMB_PTR_W-1:0]  reg_addr,
    output logic [SMB_BYTE_W-1:0] reg_wdata,
    input  logic [SMB_BYTE_W-1:0] reg_rdata
);

    logic                  scl_s;
    logic                  sda_s;
    logic                  scl_rise;
    logic                  scl_fall;
    logic                  start_det;
    logic                  stop_det;
    logic                  rx_en;
    logic                  rx_clear;
    logic                  byte_done;
    logic [SMB_BYTE_W-1:0] rx_byte;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_rx_shift #(
        .BITS (SMB_BYTE_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .shift_en  (rx_en),
        .scl_rise  (scl_rise),
        .sda_s     (sda_s),
        .rx_byte   (rx_byte),
        .byte_done (byte_done)
    );

    smb_proto_fsm #(
        .SLAVE_ADDR  (SLAVE_ADDR),
        .BLOCK_COUNT (BLOCK_COUNT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .rx_en     (rx_en),
        .rx_clear  (rx_clear),
        .sda_pull  (sda_pull),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sda_pull && !reg_wr_en)); // R10

endmodule

// File: tb/smb_regslave_test.sv
// Scoreboard bench: bus tasks queue the register writes they expect, and a
// monitor pops and compares each strobe. Read bytes and acknowledge bits
// are compared against a shadow copy of the register file.
module smb_regslave_test;

    localparam logic [6:0] ADDR    = 7'h3A;
    localparam int         BLK_CNT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       reg_wr_en;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    wire        sda_line = sda_m & ~sda_pull;

    logic [7:0] core_mem [128];
    logic [7:0] shadow   [128];
    logic [14:0] exp_q [$];
    int n_checks = 0;
    int n_fail   = 0;
    int r8_bad   = 0;
    logic pull_prev = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    smb_regslave #(.SLAVE_ADDR(ADDR), .BLOCK_COUNT(BLK_CNT)) uut (
        .clk (clk), .rst_n (rst_n), .scl_in (scl_m), .sda_in (sda_line),
        .sda_pull (sda_pull), .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata)
    );

    // Core-side register file model
    assign reg_rdata = core_mem[reg_addr];
    always @(posedge clk) if (reg_wr_en) core_mem[reg_addr] <= reg_wdata;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor for write strobes (R9)
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected strobe: actual=%0h expected=none", {reg_addr, reg_wdata});
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                if ({reg_addr, reg_wdata} !== e) begin
                    n_fail++;
                    $display("FAIL R9 write: actual=%0h expected=%0h", {reg_addr, reg_wdata}, e);
                end
            end
        end
    end

    // R8 monitor: drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_m && (sda_pull !== pull_prev)) r8_bad++;
            pull_prev = sda_pull;
        end
    end

    task automatic q(); repeat (10) @(negedge clk); endtask

    task automatic push_wr(input logic [6:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
        shadow[a] = d;
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    endtask

    task automatic bit_r(output logic v);
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); v = sda_line; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic v;
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(v);
        check(tag, {15'd0, v}, {15'd0, ~exp_ack});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit m_ack, input string tag);
        logic [7:0] r;
        logic v;
        for (int i = 7; i >= 0; i--) begin
            bit_r(v);
            r[i] = v;
        end
        check(tag, {8'd0, r}, {8'd0, exp});
        bit_w(~m_ack);
    endtask

    task automatic byte_write(input logic [6:0] rg, input logic [7:0] d);
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte({1'b0, rg}, 1, "R2 command ack");
        push_wr(rg, d);
        send_byte(d, 1, "R3 data ack");
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] rg, input string tag);
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte({1'b0, rg}, 1, "R2 command ack");
        bus_start();
        send_byte({ADDR, 1'b1}, 1, "R5 read address ack");
        recv_byte(shadow[rg], 0, tag);
        bus_stop();
    endtask

    task automatic block_write(input logic [6:0] rg, input int n, input logic [7:0] base);
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte({1'b1, rg}, 1, "R2 block command ack");
        send_byte(8'(n), 1, "R4 count ack");
        for (int i = 0; i < n; i++) begin
            push_wr(7'(rg + i), 8'(base + i));
            send_byte(8'(base + i), 1, "R4 data ack");
        end
        send_byte(8'hEE, 0, "R4 byte beyond count refused");
        bus_stop();
    endtask

    task automatic block_read(input logic [6:0] rg);
        logic v;
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte({1'b1, rg}, 1, "R2 block command ack");
        bus_start();
        send_byte({ADDR, 1'b1}, 1, "R6 read address ack");
        recv_byte(8'(BLK_CNT), 1, "R6 count byte");
        for (int i = 0; i < BLK_CNT; i++)
            recv_byte(shadow[7'(rg + i)], i != BLK_CNT - 1, "R6 data byte");
        for (int i = 0; i < 3; i++) begin
            bit_r(v);
            check("R6 released after nack", {15'd0, v}, 16'd1);
        end
        bus_stop();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog: actual=hung expected=complete");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            core_mem[i] = 8'(i * 5 + 1);
            shadow[i]   = 8'(i * 5 + 1);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 sda released after reset", {15'd0, sda_pull}, 16'd0);
        check("R10 no strobe after reset", {15'd0, reg_wr_en}, 16'd0);

        byte_write(7'h05, 8'hA5);
        // R3: a second data byte in single-byte mode is refused
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte(8'h06, 1, "R2 command ack");
        push_wr(7'h06, 8'h11);
        send_byte(8'h11, 1, "R3 data ack");
        send_byte(8'h22, 0, "R3 second byte refused");
        bus_stop();
        byte_read(7'h05, "R5 byte read after write");
        byte_read(7'h06, "R5 byte read second reg");
        byte_read(7'h40, "R5 byte read untouched reg");

        block_write(7'h10, 3, 8'h30);
        block_write(7'h7E, 3, 8'hC0);
        block_write(7'h20, 0, 8'h00);
        block_read(7'h10);
        block_read(7'h7C);

        // R1: foreign address, rest of transfer ignored
        bus_start();
        send_byte({7'h55, 1'b0}, 0, "R1 foreign address not acked");
        send_byte(8'h05, 0, "R1 ignored command");
        send_byte(8'h99, 0, "R1 ignored data");
        bus_stop();
        byte_read(7'h05, "R1 register unchanged after foreign transfer");

        // R7: stop in the middle of a data byte
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte(8'h21, 1, "R2 command ack");
        bit_w(1); bit_w(0); bit_w(1); bit_w(0); bit_w(1);
        bus_stop();
        byte_read(7'h21, "R7 stop abort wrote nothing");

        // R7: start in the middle of a data byte restarts address reception
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R1 address ack");
        send_byte(8'h23, 1, "R2 command ack");
        bit_w(0); bit_w(1); bit_w(1); bit_w(0);
        bus_start();
        send_byte({ADDR, 1'b0}, 1, "R7 address after restart");
        send_byte(8'h24, 1, "R7 command after restart");
        push_wr(7'h24, 8'h77);
        send_byte(8'h77, 1, "R7 data after restart");
        bus_stop();
        byte_read(7'h23, "R7 restart abort wrote nothing");
        byte_read(7'h24, "R7 write after restart landed");

        repeat (20) @(negedge clk);
        check("R9 all expected writes seen", 16'(exp_q.size()), 16'd0);
        check("R8 drive changed only while SCL low", 16'(r8_bad), 16'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule